// File: doc/BRIEF.md
# Nibble-Grouped Switch Block with Control Array

This block is one tile of a programmable crosspoint fabric. It holds sixteen cells, each a multiplexer with an output register and an input register. The cells are grouped into four nibbles of four. The data side takes 64 routed lines. Each cell chooses one of four fixed lines from that set and drives it, either directly or registered, to its pin-side output. The pin-side input goes back toward the fabric, either directly or registered.

A control array turns 32 routed control lines into sixteen local controls. Each local control picks one line and may invert it. The local controls are eight nibble selects, four enables, two set/reset lines and two output enables. These are combined with global enables, a global set/reset, global selects, global output enables and a test output-enable gate.

Both register rows can also act as shift chains that run up or down the cells. Each chain has ports at cell 0 and cell 15, so neighbouring tiles can be cascaded. All configuration is held on static input vectors. Every register clocks on one system clock; the clock/enable nets act as clock enables.

Top module: `nsw_nibble_block`

## Requirements
- R1: `rst` is synchronous and active high. While it is sampled high, every output and input register clears to 0. It overrides set/reset and enables.
- R2: Control-array output k (0..15) equals `pool_ctl[L] ^ I`, where L is `cfg_ctl[6k+4:6k]` and I is `cfg_ctl[6k+5]`. The outputs are assigned as follows: outputs 0..7 are selects, 8..11 are local enables, 12..13 are local set/reset lines, and 14..15 are local output enables.
- R3: Cell c = 4n+p (nibble n, position p) has four mux inputs; input s is `pool_data[16n+4s+p]`. The 2-bit select is {output 2n+1, output 2n}. When `cfg_nib_gsel[n]` is 1, the select is `g_sel` instead.
- R4: Each cell has a 17-bit configuration record at `cfg_cell[17c+16:17c]`. Its fields are: out_mode [1:0], in_mode [3:2], out_inv [4], oe_pick [7:5], ce_out [10:8], ce_in [13:11], sr_pick [15:14] and init [16]. With out_mode 0 (bypass), `pin_out[c]` is the mux value XOR out_inv in the same cycle.
- R5: The output-register enable is chosen by ce_out: values 0..3 pick local enables 0..3, and values 4..7 pick `g_ce[0..3]`. On an enabled edge the register loads: the mux (out_mode 1, and also 0), the output register of cell c-1 (mode 2, with `ochain_up_in` for cell 0), or the output register of cell c+1 (mode 3, with `ochain_dn_in` for cell 15). Otherwise it holds. In modes 1..3, `pin_out[c]` is the register XOR out_inv.
- R6: The input register follows the same rules with ce_in and in_mode, loading `pin_in[c]` in modes 0 and 1. Its chain neighbours are `ichain_up_in` and `ichain_dn_in`. `to_pool[c]` is `pin_in[c]` in mode 0 and the register otherwise.
- R7: `ochain_up_out` is the cell 15 output register and `ochain_dn_out` is the cell 0 output register. `ichain_up_out` and `ichain_dn_out` are the same taps of the input chain.
- R8: sr_pick chooses the cell's set/reset: 0 means none, 1 means local 0, 2 means local 1 and 3 means `g_sr`. While it is active, both registers of the cell load init on the edge, ignoring their enables.
- R9: oe_pick chooses the enable: 0..1 pick local OE 0..1, 2..5 pick `g_oe[0..3]`, 6 is always on and 7 is always off. `pin_oe[c]` is that value ANDed with `g_toe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| pool_data | input | 64 | Routed data lines |
| pool_ctl | input | 32 | Routed control lines |
| g_ce | input | 4 | Global clock enables |
| g_sr | input | 1 | Global set/reset |
| g_sel | input | 2 | Global nibble select |
| g_oe | input | 4 | Global output enables |
| g_toe | input | 1 | Test output-enable gate |
| cfg_ctl | input | 96 | Control-array picks, 6 bits per output |
| cfg_nib_gsel | input | 4 | Per-nibble use of global select |
| cfg_cell | input | 272 | Per-cell configuration, 17 bits per cell |
| pin_in | input | 16 | Pin-side input data |
| pin_out | output | 16 | Pin-side output data |
| pin_oe | output | 16 | Pin-side output enable |
| to_pool | output | 16 | Input data toward the fabric |
| ochain_up_in | input | 1 | Output chain feed into cell 0 |
| ochain_dn_in | input | 1 | Output chain feed into cell 15 |
| ochain_up_out | output | 1 | Output chain tap at cell 15 |
| ochain_dn_out | output | 1 | Output chain tap at cell 0 |
| ichain_up_in | input | 1 | Input chain feed into cell 0 |
| ichain_dn_in | input | 1 | Input chain feed into cell 15 |
| ichain_up_out | output | 1 | Input chain tap at cell 15 |
| ichain_dn_out | output | 1 | Input chain tap at cell 0 |

## Verification
The following properties are checked on every cycle:
- reset clears both register rows;
- a register whose enable and set/reset are both low keeps its value;
- set/reset loads the init value regardless of the enable;
- a low test gate forces every output enable off.

Some behaviours can only be shown by the bench's scenarios, where a reference model tracks the whole block. These are:
- which routed line reaches each cell through the control-array picks, inversions and nibble selects;
- the direction and end-port behaviour of the shift chains;
- the choice among local and global enables and output enables.

// File: rtl/nsw_pkg.sv
package nsw_pkg;

    typedef enum logic [1:0] {
        MODE_BYP = 2'd0,
        MODE_REG = 2'd1,
        MODE_UP  = 2'd2,
        MODE_DN  = 2'd3
    } reg_mode_e;

    // Declared MSB first: init is bit 16, out_mode is bits 1:0.
    typedef struct packed {
        logic      init;
        logic [1:0] sr_pick;
        logic [2:0] ce_in;
        logic [2:0] ce_out;
        logic [2:0] oe_pick;
        logic      out_inv;
        reg_mode_e in_mode;
        reg_mode_e out_mode;
    } cell_cfg_t;

    localparam int CELL_CFG_W = $bits(cell_cfg_t);
    localparam int MUX_WAYS   = 4;
    localparam int LOC_CE_N   = 4;
    localparam int LOC_SR_N   = 2;
    localparam int LOC_OE_N   = 2;

    // Pick one of four local or four global enables.
    function automatic logic pick_ce(logic [2:0] pick, logic [3:0] loc, logic [3:0] glb);
        return pick[2] ? glb[pick[1:0]] : loc[pick[1:0]];
    endfunction

endpackage

// File: rtl/nsw_ctl_array.sv
module nsw_ctl_array #(
    parameter int N_IN  = 32,
    parameter int N_OUT = 16
) (
    input  logic [N_IN-1:0]                  lines,
    input  logic [N_OUT*($clog2(N_IN)+1)-1:0] cfg,
    output logic [N_OUT-1:0]                 ctl
);
    localparam int PW = $clog2(N_IN);
    localparam int EW = PW + 1;

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic [PW-1:0] line_idx;
        logic          inv;
        assign line_idx = cfg[EW*k +: PW];
        assign inv      = cfg[EW*k + PW];
        assign ctl[k]   = lines[line_idx] ^ inv;
    end
endmodule

// File: rtl/nsw_cell.sv
module nsw_cell
    import nsw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cell_cfg_t           cfg,
    input  logic [MUX_WAYS-1:0] mux_in,
    input  logic [1:0]          sel,
    input  logic [LOC_CE_N-1:0] l_ce,
    input  logic [3:0]          g_ce,
    input  logic [LOC_SR_N-1:0] l_sr,
    input  logic                g_sr,
    input  logic [LOC_OE_N-1:0] l_oe,
    input  logic [3:0]          g_oe,
    input  logic                g_toe,
    input  logic                pin_in,
    input  logic                o_lo_nb,
    input  logic                o_hi_nb,
    input  logic                i_lo_nb,
    input  logic                i_hi_nb,
    output logic                pin_out,
    output logic                pin_oe,
    output logic                to_pool,
    output logic                oreg,
    output logic                ireg,
    output logic                out_ce,
    output logic                in_ce,
    output logic                sr_hit
);
    logic mux_o, o_d, i_d, oe_sel;

    always_comb begin
        mux_o  = mux_in[sel];
        out_ce = pick_ce(cfg.ce_out, l_ce, g_ce);
        in_ce  = pick_ce(cfg.ce_in,  l_ce, g_ce);
        unique case (cfg.sr_pick)
            2'd0:    sr_hit = 1'b0;
            2'd1:    sr_hit = l_sr[0];
            2'd2:    sr_hit = l_sr[1];
            default: sr_hit = g_sr;
        endcase
        unique case (cfg.out_mode)
            MODE_UP: o_d = o_lo_nb;
            MODE_DN: o_d = o_hi_nb;
            default: o_d = mux_o;
        endcase
        unique case (cfg.in_mode)
            MODE_UP: i_d = i_lo_nb;
            MODE_DN: i_d = i_hi_nb;
            default: i_d = pin_in;
        endcase
        unique case (cfg.oe_pick)
            3'd0:    oe_sel = l_oe[0];
            3'd1:    oe_sel = l_oe[1];
            3'd2:    oe_sel = g_oe[0];
            3'd3:    oe_sel = g_oe[1];
            3'd4:    oe_sel = g_oe[2];
            3'd5:    oe_sel = g_oe[3];
            3'd6:    oe_sel = 1'b1;
            default: oe_sel = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oreg <= 1'b0;
            ireg <= 1'b0;
        end else if (sr_hit) begin
            oreg <= cfg.init;
            ireg <= cfg.init;
        end else begin
            if (out_ce) oreg <= o_d;
            if (in_ce)  ireg <= i_d;
        end
    end

    assign pin_out = ((cfg.out_mode == MODE_BYP) ? mux_o : oreg) ^ cfg.out_inv;
    assign to_pool = (cfg.in_mode == MODE_BYP) ? pin_in : ireg;
    assign pin_oe  = oe_sel & g_toe;
endmodule

// File: rtl/nsw_nibble_block.sv
module nsw_nibble_block
    import nsw_pkg::*;
#(
    parameter int N_CELL    = 16,
    parameter int NIB_CELLS = 4,
    parameter int N_CTL     = 32,
    localparam int N_NIB     = N_CELL / NIB_CELLS,
    localparam int N_DATA    = MUX_WAYS * N_CELL,
    localparam int N_LOC     = 2 * N_NIB + LOC_CE_N + LOC_SR_N + LOC_OE_N,
    localparam int CTL_CFG_W = $clog2(N_CTL) + 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_DATA-1:0]            pool_data,
    input  logic [N_CTL-1:0]             pool_ctl,
    input  logic [3:0]                   g_ce,
    input  logic                         g_sr,
    input  logic [1:0]                   g_sel,
    input  logic [3:0]                   g_oe,
    input  logic                         g_toe,
    input  logic [N_LOC*CTL_CFG_W-1:0]   cfg_ctl,
    input  logic [N_NIB-1:0]             cfg_nib_gsel,
    input  logic [N_CELL*CELL_CFG_W-1:0] cfg_cell,
    input  logic [N_CELL-1:0]            pin_in,
    output logic [N_CELL-1:0]            pin_out,
    output logic [N_CELL-1:0]            pin_oe,
    output logic [N_CELL-1:0]            to_pool,
    input  logic                         ochain_up_in,
    input  logic                         ochain_dn_in,
    output logic                         ochain_up_out,
    output logic                         ochain_dn_out,
    input  logic                         ichain_up_in,
    input  logic                         ichain_dn_in,
    output logic                         ichain_up_out,
    output logic                         ichain_dn_out
);
    localparam int CE_BASE = 2 * N_NIB;
    localparam int SR_BASE = CE_BASE + LOC_CE_N;
    localparam int OE_BASE = SR_BASE + LOC_SR_N;

    logic [N_LOC-1:0]  loc;
    logic [N_CELL-1:0] oreg_q, ireg_q, out_ce_v, in_ce_v, sr_hit_v, init_v;

    nsw_ctl_array #(.N_IN(N_CTL), .N_OUT(N_LOC)) i_ctl_array (
        .lines (pool_ctl),
        .cfg   (cfg_ctl),
        .ctl   (loc)
    );

    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
        localparam int NB = c / NIB_CELLS;
        localparam int PS = c % NIB_CELLS;
        cell_cfg_t           cc;
        logic [MUX_WAYS-1:0] mux_in;
        logic [1:0]          sel;
        logic                o_lo, o_hi, i_lo, i_hi;

        assign cc  = cell_cfg_t'(cfg_cell[CELL_CFG_W*c +: CELL_CFG_W]);
        assign sel = cfg_nib_gsel[NB] ? g_sel : loc[2*NB +: 2];
        assign init_v[c] = cc.init;

        for (genvar s = 0; s < MUX_WAYS; s++) begin : g_way
            assign mux_in[s] = pool_data[NB*MUX_WAYS*NIB_CELLS + s*NIB_CELLS + PS];
        end

        if (c == 0) begin : g_lo_end
            assign o_lo = ochain_up_in;
            assign i_lo = ichain_up_in;
        end else begin : g_lo_mid
            assign o_lo = oreg_q[c-1];
            assign i_lo = ireg_q[c-1];
        end
        if (c == N_CELL-1) begin : g_hi_end
            assign o_hi = ochain_dn_in;
            assign i_hi = ichain_dn_in;
        end else begin : g_hi_mid
            assign o_hi = oreg_q[c+1];
            assign i_hi = ireg_q[c+1];
        end

        nsw_cell i_cell (
            .clk     (clk),
            .rst     (rst),
            .cfg     (cc),
            .mux_in  (mux_in),
            .sel     (sel),
            .l_ce    (loc[CE_BASE +: LOC_CE_N]),
            .g_ce    (g_ce),
            .l_sr    (loc[SR_BASE +: LOC_SR_N]),
            .g_sr    (g_sr),
            .l_oe    (loc[OE_BASE +: LOC_OE_N]),
            .g_oe    (g_oe),
            .g_toe   (g_toe),
            .pin_in  (pin_in[c]),
            .o_lo_nb (o_lo),
            .o_hi_nb (o_hi),
            .i_lo_nb (i_lo),
            .i_hi_nb (i_hi),
            .pin_out (pin_out[c]),
            .pin_oe  (pin_oe[c]),
            .to_pool (to_pool[c]),
            .oreg    (oreg_q[c]),
            .ireg    (ireg_q[c]),
            .out_ce  (out_ce_v[c]),
            .in_ce   (in_ce_v[c]),
            .sr_hit  (sr_hit_v[c])
        );
    end

    assign ochain_up_out = oreg_q[N_CELL-1];
    assign ochain_dn_out = oreg_q[0];
    assign ichain_up_out = ireg_q[N_CELL-1];
    assign ichain_dn_out = ireg_q[0];
endmodule

// File: rtl/nsw_nibble_block_chk.sv
module nsw_nibble_block_chk #(
    parameter int N_CELL = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              g_toe,
    input logic [N_CELL-1:0] pin_oe,
    input logic [N_CELL-1:0] oreg_q,
    input logic [N_CELL-1:0] ireg_q,
    input logic [N_CELL-1:0] out_ce_v,
    input logic [N_CELL-1:0] in_ce_v,
    input logic [N_CELL-1:0] sr_hit_v,
    input logic [N_CELL-1:0] init_v
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (oreg_q == '0 && ireg_q == '0));

    assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((oreg_q ^ $past(oreg_q)) & $past(~out_ce_v & ~sr_hit_v)) == '0);

    assert_in_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((ireg_q ^ $past(ireg_q)) & $past(~in_ce_v & ~sr_hit_v)) == '0);

    assert_sr_init_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((((oreg_q ^ $past(init_v)) | (ireg_q ^ $past(init_v)))
                          & $past(sr_hit_v)) == '0));

    assert_toe_gate_R9: assert property (@(posedge clk) disable iff (rst)
        !g_toe |-> pin_oe == '0);
endmodule

bind nsw_nibble_block nsw_nibble_block_chk #(.N_CELL(N_CELL)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .g_toe    (g_toe),
    .pin_oe   (pin_oe),
    .oreg_q   (oreg_q),
    .ireg_q   (ireg_q),
    .out_ce_v (out_ce_v),
    .in_ce_v  (in_ce_v),
    .sr_hit_v (sr_hit_v),
    .init_v   (init_v)
);

// File: tb/test_nsw_nibble_block.sv
module test_nsw_nibble_block;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst;
    logic [63:0]  pool_data;
    logic [31:0]  pool_ctl;
    logic [3:0]   g_ce, g_oe;
    logic         g_sr, g_toe;
    logic [1:0]   g_sel;
    logic [95:0]  cfg_ctl;
    logic [3:0]   cfg_nib_gsel;
    logic [271:0] cfg_cell;
    logic [15:0]  pin_in, pin_out, pin_oe, to_pool;
    logic ochain_up_in, ochain_dn_in, ochain_up_out, ochain_dn_out;
    logic ichain_up_in, ichain_dn_in, ichain_up_out, ichain_dn_out;

    nsw_nibble_block i_nsw_nibble_block (
        .clk(clk), .rst(rst), .pool_data(pool_data), .pool_ctl(pool_ctl),
        .g_ce(g_ce), .g_sr(g_sr), .g_sel(g_sel), .g_oe(g_oe), .g_toe(g_toe),
        .cfg_ctl(cfg_ctl), .cfg_nib_gsel(cfg_nib_gsel), .cfg_cell(cfg_cell),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .to_pool(to_pool),
        .ochain_up_in(ochain_up_in), .ochain_dn_in(ochain_dn_in),
        .ochain_up_out(ochain_up_out), .ochain_dn_out(ochain_dn_out),
        .ichain_up_in(ichain_up_in), .ichain_dn_in(ichain_dn_in),
        .ichain_up_out(ichain_up_out), .ichain_dn_out(ichain_dn_out)
    );

    int n_chk = 0;
    int n_fail = 0;

    // configuration fields and register model
    int ctl_line [16];
    bit ctl_inv  [16];
    int c_om [16], c_im [16], c_oe [16], c_ceo [16], c_cei [16], c_sr [16];
    bit c_inv [16], c_init [16];
    bit nib_g [4];
    bit om [16], im [16];

    function automatic bit ctl_f(int k);
        return pool_ctl[ctl_line[k]] ^ ctl_inv[k];
    endfunction

    function automatic bit mux_f(int c);
        int n = c / 4;
        int p = c % 4;
        int s = nib_g[n] ? int'(g_sel) : (int'(ctl_f(2*n+1)) * 2 + int'(ctl_f(2*n)));
        return pool_data[16*n + 4*s + p];
    endfunction

    function automatic bit ce_f(int pick);
        return (pick < 4) ? ctl_f(8 + pick) : g_ce[pick-4];
    endfunction

    function automatic bit sr_f(int pick);
        case (pick)
            0: return 1'b0;
            1: return ctl_f(12);
            2: return ctl_f(13);
            default: return g_sr;
        endcase
    endfunction

    function automatic bit oe_f(int pick);
        if (pick < 2) return ctl_f(14 + pick);
        if (pick < 6) return g_oe[pick-2];
        return (pick == 6);
    endfunction

    task automatic pack_cfg();
        for (int k = 0; k < 16; k++) begin
            cfg_ctl[6*k +: 5] = 5'(ctl_line[k]);
            cfg_ctl[6*k + 5]  = ctl_inv[k];
        end
        for (int n = 0; n < 4; n++) cfg_nib_gsel[n] = nib_g[n];
        for (int c = 0; c < 16; c++) begin
            cfg_cell[17*c +: 2]      = 2'(c_om[c]);
            cfg_cell[17*c + 2 +: 2]  = 2'(c_im[c]);
            cfg_cell[17*c + 4]       = c_inv[c];
            cfg_cell[17*c + 5 +: 3]  = 3'(c_oe[c]);
            cfg_cell[17*c + 8 +: 3]  = 3'(c_ceo[c]);
            cfg_cell[17*c + 11 +: 3] = 3'(c_cei[c]);
            cfg_cell[17*c + 14 +: 2] = 2'(c_sr[c]);
            cfg_cell[17*c + 16]      = c_init[c];
        end
    endtask

    // kind 0: random, 1: all shift up, 2: all shift down
    task automatic gen_cfg(int kind);
        for (int k = 0; k < 16; k++) begin
            ctl_line[k] = $urandom_range(0, 31);
            ctl_inv[k]  = 1'($urandom_range(0, 1));
        end
        for (int n = 0; n < 4; n++) nib_g[n] = 1'($urandom_range(0, 1));
        for (int c = 0; c < 16; c++) begin
            c_om[c]   = (kind == 0) ? $urandom_range(0, 3) : kind + 1;
            c_im[c]   = (kind == 0) ? $urandom_range(0, 3) : kind + 1;
            c_inv[c]  = 1'($urandom_range(0, 1));
            c_oe[c]   = $urandom_range(0, 7);
            c_ceo[c]  = (kind == 0) ? $urandom_range(0, 7) : 4;
            c_cei[c]  = (kind == 0) ? $urandom_range(0, 7) : 5;
            c_sr[c]   = (kind == 0) ? $urandom_range(0, 3) : 0;
            c_init[c] = 1'($urandom_range(0, 1));
        end
        pack_cfg();
    endtask

    task automatic rand_inputs();
        pool_data    = {$urandom, $urandom};
        pool_ctl     = $urandom;
        g_ce         = 4'($urandom);
        g_sr         = ($urandom_range(0, 7) == 0);
        g_sel        = 2'($urandom);
        g_oe         = 4'($urandom);
        g_toe        = ($urandom_range(0, 3) != 0);
        pin_in       = 16'($urandom);
        ochain_up_in = 1'($urandom);
        ochain_dn_in = 1'($urandom);
        ichain_up_in = 1'($urandom);
        ichain_dn_in = 1'($urandom);
    endtask

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [15:0] e_out, e_oe, e_pool;
        for (int c = 0; c < 16; c++) begin
            e_out[c]  = ((c_om[c] == 0) ? mux_f(c) : om[c]) ^ c_inv[c];
            e_oe[c]   = oe_f(c_oe[c]) & g_toe;
            e_pool[c] = (c_im[c] == 0) ? pin_in[c] : im[c];
        end
        check("R2 R3 R4 R5 R8 pin_out", pin_out, e_out);
        check("R2 R9 pin_oe", pin_oe, e_oe);
        check("R6 to_pool", to_pool, e_pool);
        check("R7 chain taps",
              {12'd0, ochain_up_out, ochain_dn_out, ichain_up_out, ichain_dn_out},
              {12'd0, om[15], om[0], im[15], im[0]});
    endtask

    // advance one clock, updating the model from the inputs present
    task automatic step();
        bit no [16];
        bit ni [16];
        for (int c = 0; c < 16; c++) begin
            no[c] = om[c];
            ni[c] = im[c];
            if (sr_f(c_sr[c])) begin
                no[c] = c_init[c];
                ni[c] = c_init[c];
            end else begin
                if (ce_f(c_ceo[c]))
                    no[c] = (c_om[c] == 2) ? ((c == 0) ? ochain_up_in : om[c-1]) :
                            (c_om[c] == 3) ? ((c == 15) ? ochain_dn_in : om[c+1]) : mux_f(c);
                if (ce_f(c_cei[c]))
                    ni[c] = (c_im[c] == 2) ? ((c == 0) ? ichain_up_in : im[c-1]) :
                            (c_im[c] == 3) ? ((c == 15) ? ichain_dn_in : im[c+1]) : pin_in[c];
            end
        end
        @(posedge clk);
        om = no;
        im = ni;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1e5c_0b7d));
        rst = 1'b1;
        gen_cfg(0);
        for (int c = 0; c < 16; c++) begin
            c_om[c] = 1; c_im[c] = 1; c_inv[c] = 0; c_sr[c] = 3;
        end
        pack_cfg();
        rand_inputs();
        g_sr = 1'b1;
        for (int c = 0; c < 16; c++) begin om[c] = 0; im[c] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset wins over an active global set/reset
        check("R1 reset pin_out", pin_out, 16'h0);
        check("R1 reset to_pool", to_pool, 16'h0);
        check("R1 reset chain taps",
              {12'd0, ochain_up_out, ochain_dn_out, ichain_up_out, ichain_dn_out}, 16'h0);
        rst = 1'b0;

        for (int phase = 0; phase < 40; phase++) begin
            gen_cfg((phase % 8 == 3) ? 1 : (phase % 8 == 6) ? 2 : 0);
            for (int cyc = 0; cyc < 64; cyc++) begin
                rand_inputs();
                if (phase % 8 == 3 || phase % 8 == 6) begin
                    g_sr = 1'b0;
                    g_ce[0] = 1'b1;
                end
                if (phase == 5) g_toe = 1'b0;   // R9 test gate held off
                #2;
                compare_all();
                step();
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule